// File: doc/BRIEF.md
# Serial ADC Frame Readout Controller

This block is the master side of a three-wire serial link to a 16-bit successive-approximation converter. The three wires are an active-low select, a serial clock and a serial data input. A start request opens one read frame. The controller waits until the select line has been high for long enough, then drives the select low and issues either a 20-clock or a 24-clock burst on the serial clock. It collects the incoming bits and checks the zero bits that frame the result. It then returns a 16-bit straight-binary word together with a one-cycle valid strobe and a framing-error flag.

A frame is made of four zero bits, then the 16 result bits with the most significant bit first. In the long mode, four more zero bits follow the result. The short mode stops after the result bits and never samples the trailing zeros. The serial clock comes from the system clock through a run-time half-period divider. An idle-hold request can keep the converter deselected between bursts, so that it stays quiet and draws little power.

Top module: `sar_frame_reader`

## Requirements
- R1: After reset, `cs_n_o` and `sclk_o` are high, and `busy_o`, `valid_o`, `frm_err_o` and `result_o` are all zero.
- R2: When `long_frame_i` is 1 at the accepted start, a frame has exactly 24 rising edges of `sclk_o` while `cs_n_o` is low. When it is 0, a frame has exactly 20.
- R3: Bit positions count from 1 at the first rising edge. `result_o` is made of the bits sampled at positions 5 to 20, with position 5 as bit 15 (MSB first, straight binary: 0x0000 is zero input, 0xFFFF is full scale less one LSB).
- R4: `frm_err_o` is 1 together with `valid_o` when any of sampled positions 1 to 4 is one. In long mode it is also 1 when any of positions 21 to 24 is one. In short mode the line level after position 20 has no effect.
- R5: `sclk_o` is high whenever `cs_n_o` is high. Inside a frame each low phase lasts `div_i` system clocks, and the value 0 counts as 1. Data is sampled on the rising edge.
- R6: Between the end of one frame and the fall of `cs_n_o` for the next, `cs_n_o` stays high for at least `gap_i` system clocks.
- R7: A start request while `busy_o` is high is ignored and produces no extra frame or strobe.
- R8: `busy_o` rises in the cycle after an accepted start and falls in the same cycle that `valid_o` pulses. `valid_o` lasts one cycle. `result_o` and `frm_err_o` hold their values until the next strobe.
- R9: While `pd_req_i` is 1 and the controller is idle, start requests are ignored, and `cs_n_o` and `sclk_o` stay high.
- R10: The frame mode is taken from `long_frame_i` at the accepted start. Changing it during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one read frame |
| long_frame_i | input | 1 | 1: 24-clock frame, 0: 20-clock frame |
| pd_req_i | input | 1 | Hold the converter deselected and refuse starts |
| div_i | input | DIV_W (8) | Serial clock half-period in system clocks |
| gap_i | input | GAP_W (8) | Minimum select-high time in system clocks |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | RES_W (16) | Conversion result |
| frm_err_o | output | 1 | Framing error for the current result |

## Verification
The bench builds the block with its default parameters: a 16-bit result, four leading and four trailing zero bits, 8-bit divider and gap fields, the idle-hold option present and zero checking enabled. With these values it can set divider settings of 0, 1, 2 and 3, so the low-phase count and the clamping of 0 to 1 can be observed. It can also set short and long gap values and inject ones into the leading and trailing zero bits of either frame mode. The idle-hold path and the latching of the mode at start are reachable only because the option is built in.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GAP   = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TAIL  = 2'd3
   } sfr_state_e;

endpackage

// File: rtl/sfr_sclk_gen.sv
module sfr_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold_high,
   input  logic [DIV_W-1:0] div,
   output logic             sclk,
   output logic             rise_now,
   output logic             phase_end
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   if (DIV_W < 1) begin : g_bad_div
      $error("sfr_sclk_gen: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] hc;
   logic [DIV_W-1:0] lim;

   assign lim       = (div == '0) ? ONE : div;
   assign phase_end = run && (hc == lim - ONE);
   assign rise_now  = phase_end && !sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc   <= '0;
         sclk <= 1'b1;
      end else if (!run) begin
         hc   <= '0;
         sclk <= 1'b1;
      end else if (phase_end) begin
         hc <= '0;
         if (!sclk)
            sclk <= 1'b1;
         else if (!hold_high)
            sclk <= 1'b0;
      end else begin
         hc <= hc + ONE;
      end
   end

   // R5: a stopped generator parks the clock high
   a_r5_park_high: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sclk);

   // R5: while holding high the clock never falls
   a_r5_hold_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run && hold_high && sclk) |=> sclk);

endmodule

// File: rtl/sfr_capture.sv
module sfr_capture #(
   parameter int RES_W       = 16,
   parameter int LEAD_W      = 4,
   parameter int TRAIL_W     = 4,
   parameter bit CHECK_ZEROS = 1'b1,
   localparam int FR_MAX     = LEAD_W + RES_W + TRAIL_W,
   localparam int CNT_W      = $clog2(FR_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sample,
   input  logic             sdata,
   input  logic             long_mode,
   output logic [CNT_W-1:0] count,
   output logic [RES_W-1:0] word,
   output logic             err
);
   localparam int FR_MIN = LEAD_W + RES_W;

   if (RES_W < 1 || LEAD_W < 1 || TRAIL_W < 1) begin : g_bad_cfg
      $error("sfr_capture: field widths must be at least 1");
   end

   logic [FR_MAX-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         count <= '0;
      end else if (clear) begin
         shreg <= '0;
         count <= '0;
      end else if (sample) begin
         shreg <= {shreg[FR_MAX-2:0], sdata};
         count <= count + CNT_W'(1);
      end
   end

   logic [RES_W-1:0]  word_long, word_short;
   logic [LEAD_W-1:0] lead_long, lead_short;
   logic [TRAIL_W-1:0] trail_bits;

   assign word_long  = shreg[TRAIL_W +: RES_W];
   assign word_short = shreg[RES_W-1:0];
   assign lead_long  = shreg[FR_MAX-1 -: LEAD_W];
   assign lead_short = shreg[FR_MIN-1 -: LEAD_W];
   assign trail_bits = shreg[TRAIL_W-1:0];
   assign word       = long_mode ? word_long : word_short;

   if (CHECK_ZEROS) begin : g_check
      assign err = long_mode ? ((|lead_long) || (|trail_bits)) : (|lead_short);
   end else begin : g_nocheck
      assign err = 1'b0;
   end

   // R2: never more bits than the longest frame
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(FR_MAX));

   // R2: a clear empties the bit counter
   a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

endmodule

// File: rtl/sfr_gap_timer.sv
module sfr_gap_timer #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_high,
   input  logic [GAP_W-1:0] gap,
   output logic             met
);
   localparam logic [GAP_W-1:0] SAT = '1;

   if (GAP_W < 1) begin : g_bad_gap
      $error("sfr_gap_timer: GAP_W must be at least 1");
   end

   logic [GAP_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= SAT;
      else if (!cs_high)
         cnt <= '0;
      else if (cnt != SAT)
         cnt <= cnt + GAP_W'(1);
   end

   assign met = cs_high && (cnt >= gap);

   // R6: the count never moves while the select is low
   a_r6_low_resets: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_high && $past(!cs_high)) |-> (cnt == '0));

endmodule

// File: rtl/sar_frame_reader.sv
module sar_frame_reader
   import sfr_pkg::*;
#(
   parameter int RES_W       = 16,
   parameter int LEAD_W      = 4,
   parameter int TRAIL_W     = 4,
   parameter int DIV_W       = 8,
   parameter int GAP_W       = 8,
   parameter bit HAS_PD      = 1'b1,
   parameter bit CHECK_ZEROS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             long_frame_i,
   input  logic             pd_req_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic             cs_n_o,
   output logic             sclk_o,
   input  logic             sdata_i,
   output logic             busy_o,
   output logic             valid_o,
   output logic [RES_W-1:0] result_o,
   output logic             frm_err_o
);
   localparam int FR_MAX = LEAD_W + RES_W + TRAIL_W;
   localparam int FR_MIN = LEAD_W + RES_W;
   localparam int CNT_W  = $clog2(FR_MAX + 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(FR_MAX - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(FR_MIN - 1);

   sfr_state_e       state;
   logic             long_q;
   logic             start_ok;
   logic             gap_met;
   logic             run, hold_high, rise_now, phase_end;
   logic             sample, clear, last_bit;
   logic [CNT_W-1:0] bit_cnt;
   logic [RES_W-1:0] cap_word;
   logic             cap_err;

   if (HAS_PD) begin : g_pd
      assign start_ok = start_i && !pd_req_i;
   end else begin : g_nopd
      assign start_ok = start_i;
   end

   assign run       = (state == ST_SHIFT) || (state == ST_TAIL);
   assign hold_high = (state == ST_TAIL);
   assign sample    = (state == ST_SHIFT) && rise_now;
   assign clear     = (state == ST_GAP) && gap_met;
   assign last_bit  = sample && (bit_cnt == (long_q ? LAST_LONG : LAST_SHORT));
   assign busy_o    = (state != ST_IDLE);

   sfr_sclk_gen #(.DIV_W(DIV_W)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .hold_high (hold_high),
      .div       (div_i),
      .sclk      (sclk_o),
      .rise_now  (rise_now),
      .phase_end (phase_end)
   );

   sfr_capture #(
      .RES_W       (RES_W),
      .LEAD_W      (LEAD_W),
      .TRAIL_W     (TRAIL_W),
      .CHECK_ZEROS (CHECK_ZEROS)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .sample    (sample),
      .sdata     (sdata_i),
      .long_mode (long_q),
      .count     (bit_cnt),
      .word      (cap_word),
      .err       (cap_err)
   );

   sfr_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_high (cs_n_o),
      .gap     (gap_i),
      .met     (gap_met)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         long_q    <= 1'b0;
         cs_n_o    <= 1'b1;
         valid_o   <= 1'b0;
         result_o  <= '0;
         frm_err_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_ok) begin
                  long_q <= long_frame_i;
                  state  <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_met) begin
                  cs_n_o <= 1'b0;
                  state  <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (last_bit)
                  state <= ST_TAIL;
            end
            ST_TAIL: begin
               if (phase_end) begin
                  cs_n_o    <= 1'b1;
                  valid_o   <= 1'b1;
                  result_o  <= cap_word;
                  frm_err_o <= cap_err;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: the serial clock only moves while selected
   a_r5_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   // R8: a selected converter always means busy
   a_r8_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_o |-> busy_o);

   // R8: strobe is a single cycle and coincides with busy low
   a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   a_r8_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !busy_o);

   // R6: the select only falls after the gap has elapsed
   a_r6_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> $past(gap_met));

   // R10: mode is frozen during a frame
   a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(long_q));

   if (HAS_PD) begin : g_pd_chk
      // R9: idle-hold refuses starts
      a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (!busy_o && pd_req_i) |=> !busy_o);
   end

endmodule

// File: tb/sar_frame_reader_test.sv
module sar_frame_reader_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        long_frame_i = 1'b1;
   logic        pd_req_i = 1'b0;
   logic [7:0]  div_i = 8'd2;
   logic [7:0]  gap_i = 8'd5;
   logic        sdata_i = 1'b1;
   logic        cs_n_o, sclk_o, busy_o, valid_o, frm_err_o;
   logic [15:0] result_o;

   always #5 clk = ~clk;

   sar_frame_reader uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_frame_i(long_frame_i),
      .pd_req_i(pd_req_i), .div_i(div_i), .gap_i(gap_i), .cs_n_o(cs_n_o),
      .sclk_o(sclk_o), .sdata_i(sdata_i), .busy_o(busy_o), .valid_o(valid_o),
      .result_o(result_o), .frm_err_o(frm_err_o)
   );

   typedef struct {
      logic [15:0] w;
      logic        err;
      int          nbits;
      int          dv;
   } exp_t;

   exp_t  q[$];
   int    nchk = 0;
   int    nerr = 0;
   logic [23:0] sbits = '0;
   int    sidx = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // converter model: next bit after every falling edge of the serial clock
   always @(negedge cs_n_o, negedge sclk_o) begin
      if (sclk_o)
         sidx = 0;
      else if (!cs_n_o) begin
         sdata_i = (sidx < 24) ? sbits[23 - sidx] : 1'b1;
         sidx++;
      end
   end

   // monitor / scoreboard
   logic prev_sclk = 1'b1, prev_cs = 1'b1;
   int   rises = 0, lows = 0, hi = 0, frames = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n_o && sclk_o && !prev_sclk) rises++;
         if (!cs_n_o && !sclk_o) lows++;
         if (cs_n_o) hi++;
         if (prev_cs && !cs_n_o) begin
            if (frames > 0)
               chk(hi >= int'(gap_i), "R6 select-high gap", hi, gap_i);
            hi = 0; rises = 0; lows = 0;
         end
         if (valid_o) begin
            frames++;
            if (q.size() == 0)
               chk(1'b0, "R7 unexpected strobe", 1, 0);
            else begin
               exp_t e;
               e = q.pop_front();
               chk(result_o == e.w, "R3 result word", result_o, e.w);
               chk(frm_err_o == e.err, "R4 framing flag", frm_err_o, e.err);
               chk(rises == e.nbits, "R2 clock count", rises, e.nbits);
               chk(lows == e.nbits * e.dv, "R5 low-phase cycles", lows, e.nbits * e.dv);
               chk(!busy_o, "R8 busy drops with strobe", busy_o, 0);
            end
         end
         prev_sclk = sclk_o;
         prev_cs   = cs_n_o;
      end
   end

   task automatic frame(input bit lng, input logic [15:0] w, input logic [3:0] lead,
                        input logic [3:0] trail, input int dv, input bit noise);
      exp_t e;
      while (busy_o) @(negedge clk);
      div_i        = 8'(dv);
      long_frame_i = lng;
      sbits        = {lead, w, trail};
      e.w     = w;
      e.err   = (|lead) || (lng && (|trail));
      e.nbits = lng ? 24 : 20;
      e.dv    = (dv == 0) ? 1 : dv;
      q.push_back(e);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o, "R8 busy after start", busy_o, 1);
      if (noise) begin
         repeat (15) @(negedge clk);
         start_i = 1'b1;           // R7: ignored while busy
         long_frame_i = ~lng;      // R10: ignored mid-frame
         @(negedge clk);
         start_i = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cs_n_o && sclk_o, "R1 select and clock high", {cs_n_o, sclk_o}, 2'b11);
      chk(!busy_o && !valid_o && !frm_err_o, "R1 flags low",
          {busy_o, valid_o, frm_err_o}, 0);
      chk(result_o == 16'h0, "R1 result zero", result_o, 0);

      frame(1'b1, 16'hA5C3, 4'h0, 4'h0, 2, 1'b0);
      frame(1'b0, 16'h1234, 4'h0, 4'h0, 1, 1'b0);
      frame(1'b1, 16'hFFFF, 4'h0, 4'h0, 3, 1'b0);   // R3 full scale
      frame(1'b1, 16'h0000, 4'h0, 4'h0, 1, 1'b0);   // R3 zero
      frame(1'b0, 16'h8001, 4'h0, 4'hF, 2, 1'b0);   // R4 short ignores trailing
      frame(1'b1, 16'h8001, 4'h0, 4'h1, 1, 1'b0);   // R4 long trailing one
      frame(1'b0, 16'h7FFE, 4'h8, 4'h0, 1, 1'b0);   // R4 leading one
      frame(1'b1, 16'h0F0F, 4'h0, 4'h0, 2, 1'b1);   // R7 and R10
      frame(1'b0, 16'hBEEF, 4'h0, 4'h0, 0, 1'b0);   // R5 divider 0 acts as 1
      gap_i = 8'd20;
      frame(1'b1, 16'h3C5A, 4'h0, 4'h0, 1, 1'b0);   // R6 longer gap
      frame(1'b0, 16'h55AA, 4'h2, 4'h0, 1, 1'b0);

      while (busy_o || q.size() != 0) @(negedge clk);
      // R9 idle-hold refuses starts
      pd_req_i = 1'b1;
      start_i  = 1'b1;
      @(negedge clk);
      start_i  = 1'b0;
      begin
         bit stayed;
         stayed = 1'b1;
         for (int i = 0; i < 40; i++) begin
            if (!cs_n_o || !sclk_o || busy_o) stayed = 1'b0;
            @(negedge clk);
         end
         chk(stayed, "R9 held idle under power-down request", stayed, 1);
      end
      pd_req_i = 1'b0;
      frame(1'b1, 16'h9009, 4'h0, 4'h0, 1, 1'b0);

      while (busy_o || q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R2 all frames completed", q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule